// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single host write requests into correctly timed strobe sequences for an external 16-bit asynchronous static RAM. It produces a chip select, a write strobe, a read (output) enable and one enable per byte lane, all active low. It also produces the address and the data word, and a per-lane drive enable that the pad ring uses to control the tristate drivers of the bidirectional data pins. Every edge falls on a system clock edge. Every timing figure is a parameter counted in clock cycles.

The host presents an address, a data word and a two-bit lane mask, and raises `host_req`. The request is taken on a clock edge where `host_ready` is high. Each write is controlled by the write strobe: chip select and the lane enables open the cycle, the write strobe falls later, and the write strobe rising is the edge that ends the write. Chip select and the lane enables are released only after that edge. The `OE_LOW` parameter selects whether the read enable stays low or stays high. With it low, the memory drives the data pins at the start of the cycle, so the write pulse is stretched and the local drivers wait until the memory has let go of the pins. A mask of zero completes as an empty request and moves no strobe.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is asserted, chip select, write strobe, read enable and both lane enables are high, both drive enables are low, and `host_ready` is low. `host_ready` rises on the first clock edge after reset is released.
- R2: A request is taken only on an edge where `host_req` and `host_ready` are both high. After a non-empty request, `host_ready` stays low for SPAN cycles, where SPAN = max(T_WC, T_SA + PW + max(T_HA, T_HD, 1)). A request held high during those cycles has no effect.
- R3: Chip select and the selected lane enables fall on the edge that takes the request. The write strobe falls T_SA cycles later and is low only while chip select and at least one lane enable are low.
- R4: The write strobe stays low for PW cycles. With `OE_LOW`=1, PW = max(T_PWE, T_HZWE + T_SD). With `OE_LOW`=0, PW = max(T_PWE, T_SD).
- R5: The write strobe rising ends the write. Chip select and the lane enables rise max(T_HA, T_HD, 1) cycles after the write strobe rises, so they never rise first.
- R6: With `OE_LOW`=0, each selected lane is driven from the first cycle of the write. With `OE_LOW`=1, driving starts T_SD cycles before the write strobe rises, which is at least T_HZWE cycles after it fell. In both modes, driving ends T_HD cycles after the write strobe rises.
- R7: Mask bit 1 selects the upper lane (data 15:8, `mem_lane_n[1]`, `mem_drive[1]`). Mask bit 0 selects the lower lane (data 7:0, index 0). An unselected lane keeps its enable high and is never driven, so its memory byte is unchanged.
- R8: While chip select is low, `mem_addr` holds the address of the request taken and does not change. `mem_dout` carries the request's data while any lane is driven.
- R9: A request with mask 2'b00 moves no strobe and drives nothing. `host_ready` is low for exactly one cycle after it is taken.
- R10: The read enable is low on every cycle after the first edge out of reset when `OE_LOW`=1, and stays high when `OE_LOW`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Write request |
| host_ready | output | 1 | Block can take a request on this edge |
| host_addr | input | ADDR_W | Word address of the request |
| host_wdata | input | DATA_W | Write data |
| host_bmask | input | DATA_W/8 | Lane mask, bit 1 upper byte |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Read (output) enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte lane enables, active low |
| mem_dout | output | DATA_W | Data toward the memory pins |
| mem_drive | output | DATA_W/8 | Per-lane tristate drive enable |

## Verification
Two instances run side by side, one with the read enable held low and one with it held high, and each drives a behavioural memory. That memory stores a byte only when a strobe closes the write window. It also models its own drivers switching off after the write strobe falls and coming back on after it rises. A design whose drivers turned on too early under `OE_LOW`=1 would fight the memory on the pins. A design that released chip select before the write strobe would make the memory take data from the wrong edge, and one whose pulse was too short would fail the setup count. The lane masks 11, 10, 01 and 00 are each read back from the memory: a swapped lane mapping or a write during an empty request leaves a wrong byte behind. A request held high through a busy cycle shows whether the block takes work before SPAN has elapsed.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_NOP  = 2'd2
    } seq_mode_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Write strobe low time: with the memory outputs on, the pulse must
    // cover the memory's turn-off time plus data setup.
    function automatic int unsigned pulse_len(input int unsigned t_pwe,
                                              input int unsigned t_hzwe,
                                              input int unsigned t_sd,
                                              input bit          oe_low);
        return oe_low ? umax(t_pwe, t_hzwe + t_sd) : umax(t_pwe, t_sd);
    endfunction

    // Cycles chip select stays low after the write strobe rises.
    function automatic int unsigned tail_len(input int unsigned t_ha,
                                             input int unsigned t_hd);
        return umax(umax(t_ha, t_hd), 1);
    endfunction

    function automatic int unsigned span_len(input int unsigned t_sa,
                                             input int unsigned pw,
                                             input int unsigned tail,
                                             input int unsigned t_wc);
        return umax(t_wc, t_sa + pw + tail);
    endfunction

endpackage

// File: rtl/sram_wr_timeline.sv
module sram_wr_timeline
    import sram_wr_pkg::*;
#(
    parameter int unsigned T_SA   = 2,
    parameter int unsigned T_PWE  = 3,
    parameter int unsigned T_SD   = 2,
    parameter int unsigned T_HD   = 1,
    parameter int unsigned T_HA   = 2,
    parameter int unsigned T_HZWE = 3,
    parameter bit          OE_LOW = 1'b1,
    parameter int unsigned CW     = 4
) (
    input  logic          active,
    input  logic [CW-1:0] idx,
    output logic          cs_on,
    output logic          wr_on,
    output logic          drv_on
);
    localparam int unsigned PW      = pulse_len(T_PWE, T_HZWE, T_SD, OE_LOW);
    localparam int unsigned WR_BEG  = T_SA;
    localparam int unsigned WR_END  = T_SA + PW;
    localparam int unsigned DRV_BEG = OE_LOW ? (WR_END - T_SD) : 0;
    localparam int unsigned DRV_END = WR_END + T_HD;
    localparam int unsigned CS_END  = WR_END + tail_len(T_HA, T_HD);

    localparam logic [CW-1:0] WB_C = CW'(WR_BEG);
    localparam logic [CW-1:0] WE_C = CW'(WR_END);
    localparam logic [CW-1:0] DB_C = CW'(DRV_BEG);
    localparam logic [CW-1:0] DE_C = CW'(DRV_END);
    localparam logic [CW-1:0] CE_C = CW'(CS_END);

    always_comb begin
        cs_on  = active && (idx < CE_C);
        wr_on  = active && (idx >= WB_C) && (idx < WE_C);
        drv_on = active && (idx >= DB_C) && (idx < DE_C);
    end

endmodule

// File: rtl/sram_wr_lanes.sv
module sram_wr_lanes #(
    parameter int unsigned LANES = 2
) (
    input  logic             cs_on,
    input  logic             drv_on,
    input  logic [LANES-1:0] mask,
    output logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] drive
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = ~(cs_on && mask[g]);
        assign drive[g]  = drv_on && mask[g];
    end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned T_SA   = 2,
    parameter int unsigned T_PWE  = 3,
    parameter int unsigned T_SD   = 2,
    parameter int unsigned T_HD   = 1,
    parameter int unsigned T_HA   = 2,
    parameter int unsigned T_HZWE = 3,
    parameter int unsigned T_WC   = 12,
    parameter bit          OE_LOW = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    output logic                host_ready,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [DATA_W/8-1:0] host_bmask,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_cs_n,
    output logic                mem_wr_n,
    output logic                mem_rd_n,
    output logic [DATA_W/8-1:0] mem_lane_n,
    output logic [DATA_W-1:0]   mem_dout,
    output logic [DATA_W/8-1:0] mem_drive
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned PW    = pulse_len(T_PWE, T_HZWE, T_SD, OE_LOW);
    localparam int unsigned SPAN  = span_len(T_SA, PW, tail_len(T_HA, T_HD), T_WC);
    localparam int unsigned CW    = $clog2(SPAN + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(SPAN - 1);

    typedef struct packed {
        seq_mode_e         mode;
        logic [CW-1:0]     idx;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  mask;
        logic              cs_n;
        logic              wr_n;
        logic              rd_n;
        logic [LANES-1:0]  lane_n;
        logic [LANES-1:0]  drive;
        logic              ready;
    } regs_t;

    regs_t q_q, q_d;

    seq_mode_e        mode_d;
    logic [CW-1:0]    idx_d;
    logic             take;
    logic [LANES-1:0] mask_d;
    logic             cs_on, wr_on, drv_on;
    logic [LANES-1:0] lane_n_d, drive_d;

    // Sequencing: which step of the write the next cycle is in.
    always_comb begin
        mode_d = q_q.mode;
        idx_d  = q_q.idx;
        take   = 1'b0;
        unique case (q_q.mode)
            PH_IDLE: begin
                if (host_req && q_q.ready) begin
                    take   = 1'b1;
                    idx_d  = '0;
                    mode_d = (|host_bmask) ? PH_RUN : PH_NOP;
                end
            end
            PH_RUN: begin
                if (q_q.idx == LAST_IDX) begin
                    mode_d = PH_IDLE;
                end else begin
                    idx_d = q_q.idx + 1'b1;
                end
            end
            default: mode_d = PH_IDLE;
        endcase
        mask_d = take ? host_bmask : q_q.mask;
    end

    sram_wr_timeline #(
        .T_SA   (T_SA),
        .T_PWE  (T_PWE),
        .T_SD   (T_SD),
        .T_HD   (T_HD),
        .T_HA   (T_HA),
        .T_HZWE (T_HZWE),
        .OE_LOW (OE_LOW),
        .CW     (CW)
    ) u_timeline (
        .active (mode_d == PH_RUN),
        .idx    (idx_d),
        .cs_on  (cs_on),
        .wr_on  (wr_on),
        .drv_on (drv_on)
    );

    sram_wr_lanes #(
        .LANES (LANES)
    ) u_lanes (
        .cs_on  (cs_on),
        .drv_on (drv_on),
        .mask   (mask_d),
        .lane_n (lane_n_d),
        .drive  (drive_d)
    );

    always_comb begin
        q_d = q_q;
        if (take) begin
            q_d.addr = host_addr;
            q_d.data = host_wdata;
        end
        q_d.mode   = mode_d;
        q_d.idx    = idx_d;
        q_d.mask   = mask_d;
        q_d.cs_n   = ~cs_on;
        q_d.wr_n   = ~wr_on;
        q_d.rd_n   = ~OE_LOW;
        q_d.lane_n = lane_n_d;
        q_d.drive  = drive_d;
        q_d.ready  = (mode_d == PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q        <= '0;
            q_q.mode   <= PH_IDLE;
            q_q.cs_n   <= 1'b1;
            q_q.wr_n   <= 1'b1;
            q_q.rd_n   <= 1'b1;
            q_q.lane_n <= '1;
        end else begin
            q_q <= q_d;
        end
    end

    assign host_ready = q_q.ready;
    assign mem_addr   = q_q.addr;
    assign mem_cs_n   = q_q.cs_n;
    assign mem_wr_n   = q_q.wr_n;
    assign mem_rd_n   = q_q.rd_n;
    assign mem_lane_n = q_q.lane_n;
    assign mem_dout   = q_q.data;
    assign mem_drive  = q_q.drive;

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic [LANES-1:0]  mem_lane_n,
    input logic [LANES-1:0]  mem_drive
);
    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !host_ready);

    // R3
    strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!mem_cs_n && (mem_lane_n != {LANES{1'b1}})));

    // R5
    select_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> (mem_wr_n && $past(mem_wr_n)));

    // R8
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R6
    drive_after_turnoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n && $rose(|mem_drive)) |-> (!mem_wr_n && !$past(mem_wr_n)));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        // R7
        drive_needs_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_drive[i] |-> (!mem_lane_n[i] && !mem_cs_n));
    end

endmodule

bind sram_wr_seq sram_wr_seq_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (DATA_W / 8)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_wr_n   (mem_wr_n),
    .mem_rd_n   (mem_rd_n),
    .mem_lane_n (mem_lane_n),
    .mem_drive  (mem_drive)
);

// File: tb/sram_wr_seq_memchk.sv
module sram_wr_seq_memchk #(
    parameter int AW     = 8,
    parameter int T_SD   = 2,
    parameter int T_HD   = 1,
    parameter int T_HZWE = 3,
    parameter int T_LZ   = 1
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [1:0]    lane_n,
    input  logic [15:0]   dout,
    input  logic [1:0]    drive,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    output int            checks,
    output int            errors
);
    logic [15:0]   mem [0:(1<<AW)-1];
    logic [AW-1:0] p_addr;
    logic          p_cs_n, p_wr_n;
    logic [1:0]    p_lane_n;
    logic [15:0]   p_dout;
    int            drv_run [0:1];
    int            lo_run, hi_run;

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 16'h0000;
        checks = 0; errors = 0;
        p_cs_n = 1'b1; p_wr_n = 1'b1; p_lane_n = 2'b11; p_addr = '0; p_dout = '0;
        drv_run[0] = 0; drv_run[1] = 0; lo_run = 0; hi_run = 100;
    end

    assign rd_data = mem[rd_addr];

    always @(negedge clk) begin
        bit mem_on;
        if (wr_n) begin hi_run = (hi_run < 100) ? hi_run + 1 : 100; lo_run = 0; end
        else      begin lo_run = (lo_run < 100) ? lo_run + 1 : 100; hi_run = 0; end
        // memory outputs on: read enable and select low, strobe not yet
        // turned them off, or turned back on after the strobe rose
        mem_on = !cs_n && !rd_n && (wr_n ? (hi_run > T_LZ) : (lo_run <= T_HZWE));
        if (|drive) begin
            checks++;
            if (mem_on) begin
                errors++;
                $display("FAIL R6 bus contention: drive=%b memory_on=1 expected memory_on=0", drive);
            end
        end
        for (int l = 0; l < 2; l++) begin
            bit was_on, now_on;
            was_on = !p_cs_n && !p_wr_n && !p_lane_n[l];
            now_on = !cs_n && !wr_n && !lane_n[l];
            if (was_on && !now_on) begin
                checks++;
                // R5: write strobe must be the terminating edge
                if (!wr_n == 1'b0 && (cs_n || lane_n[l]) ) begin
                    errors++;
                    $display("FAIL R5 write ended by select, lane %0d: wr_n=%b cs_n=%b expected cs_n=0", l, wr_n, cs_n);
                end
                if (drv_run[l] < T_SD || (T_HD > 0 && !drive[l])) begin
                    errors++;
                    $display("FAIL R6 lane %0d setup/hold: setup=%0d hold_drive=%b expected setup>=%0d hold_drive=1",
                             l, drv_run[l], drive[l], T_SD);
                end
                mem[p_addr][l*8 +: 8] = p_dout[l*8 +: 8];
            end
            drv_run[l] = drive[l] ? drv_run[l] + 1 : 0;
        end
        p_addr = addr; p_cs_n = cs_n; p_wr_n = wr_n; p_lane_n = lane_n; p_dout = dout;
    end

endmodule

// File: tb/sram_wr_seq_bench.sv
module sram_wr_seq_bench;
    localparam int AW = 8, T_SA = 2, T_PWE = 3, T_SD = 2, T_HD = 1, T_HA = 2, T_HZWE = 3, T_WC = 12;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int PW_LO = imax(T_PWE, T_HZWE + T_SD);
    localparam int PW_HI = imax(T_PWE, T_SD);
    localparam int TAIL  = imax(imax(T_HA, T_HD), 1);
    // both instances: max(12, 2+5+2) and max(12, 2+3+2) give 12
    localparam int SPAN  = imax(T_WC, T_SA + PW_LO + TAIL);

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [15:0]   hdata = '0;
    logic [1:0]    hmask = '0;
    always #4 clk = ~clk;

    logic rdy_a, rdy_b, cs_a, cs_b, wr_a, wr_b, rd_a, rd_b;
    logic [AW-1:0] ad_a, ad_b;
    logic [1:0] ln_a, ln_b, dr_a, dr_b;
    logic [15:0] do_a, do_b, rb_a, rb_b;
    logic [AW-1:0] rd_addr = '0;
    int ck_a, er_a, ck_b, er_b;
    int checks = 0, errors = 0;
    bit done = 0;

    sram_wr_seq #(.ADDR_W(AW), .DATA_W(16), .T_SA(T_SA), .T_PWE(T_PWE), .T_SD(T_SD), .T_HD(T_HD),
                  .T_HA(T_HA), .T_HZWE(T_HZWE), .T_WC(T_WC), .OE_LOW(1'b1)) u_sram_wr_seq (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_ready(rdy_a), .host_addr(haddr),
        .host_wdata(hdata), .host_bmask(hmask), .mem_addr(ad_a), .mem_cs_n(cs_a), .mem_wr_n(wr_a),
        .mem_rd_n(rd_a), .mem_lane_n(ln_a), .mem_dout(do_a), .mem_drive(dr_a));

    sram_wr_seq #(.ADDR_W(AW), .DATA_W(16), .T_SA(T_SA), .T_PWE(T_PWE), .T_SD(T_SD), .T_HD(T_HD),
                  .T_HA(T_HA), .T_HZWE(T_HZWE), .T_WC(T_WC), .OE_LOW(1'b0)) u_sram_wr_seq_oehi (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_ready(rdy_b), .host_addr(haddr),
        .host_wdata(hdata), .host_bmask(hmask), .mem_addr(ad_b), .mem_cs_n(cs_b), .mem_wr_n(wr_b),
        .mem_rd_n(rd_b), .mem_lane_n(ln_b), .mem_dout(do_b), .mem_drive(dr_b));

    sram_wr_seq_memchk #(.AW(AW), .T_SD(T_SD), .T_HD(T_HD), .T_HZWE(T_HZWE), .T_LZ(1)) u_mem_a (
        .clk(clk), .addr(ad_a), .cs_n(cs_a), .wr_n(wr_a), .rd_n(rd_a), .lane_n(ln_a), .dout(do_a),
        .drive(dr_a), .rd_addr(rd_addr), .rd_data(rb_a), .checks(ck_a), .errors(er_a));
    sram_wr_seq_memchk #(.AW(AW), .T_SD(T_SD), .T_HD(T_HD), .T_HZWE(T_HZWE), .T_LZ(1)) u_mem_b (
        .clk(clk), .addr(ad_b), .cs_n(cs_b), .wr_n(wr_b), .rd_n(rd_b), .lane_n(ln_b), .dout(do_b),
        .drive(dr_b), .rd_addr(rd_addr), .rd_data(rb_b), .checks(ck_b), .errors(er_b));

    // ---------------- reference model ----------------
    bit            m_busy = 0, m_ready = 0, m_live = 0;
    int            m_k = 0;
    logic [1:0]    m_mask = '0;
    logic [AW-1:0] m_addr = '0;
    logic [15:0]   m_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_ready <= 0; m_live <= 0; m_k <= 0;
        end else begin
            m_live <= 1;
            if (!m_busy) begin
                if (m_ready && req) begin
                    m_busy <= (hmask != 2'b00); m_k <= 0; m_ready <= 0;
                    m_mask <= hmask; m_addr <= haddr; m_data <= hdata;
                end else begin
                    m_ready <= 1;
                end
            end else if (m_k == SPAN - 1) begin
                m_busy <= 0; m_ready <= 1;
            end else begin
                m_k <= m_k + 1;
            end
        end
    end

    // {cs_n, wr_n, rd_n, lane_n[1:0], drive[1:0]}
    function automatic logic [6:0] expect_vec(input bit oel, input int pw);
        int wb, we, ce, db, de;
        bit cs, wr, dr;
        wb = T_SA; we = T_SA + pw; ce = we + TAIL;
        db = oel ? we - T_SD : 0; de = we + T_HD;
        cs = m_busy && m_k < ce;
        wr = m_busy && m_k >= wb && m_k < we;
        dr = m_busy && m_k >= db && m_k < de;
        return {~cs, ~wr, (m_live ? ~oel : 1'b1), (cs ? ~m_mask : 2'b11), (dr ? m_mask : 2'b00)};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_inst(input string nm, input bit oel, input int pw, input logic rdy,
                              input logic cs, input logic wr, input logic rd, input logic [1:0] ln,
                              input logic [1:0] dr, input logic [AW-1:0] ad, input logic [15:0] dd);
        logic [6:0] ev;
        ev = expect_vec(oel, pw);
        // R1 R2 R3 R4 R5 R6 R7 R9 R10 strobe vector versus reference
        check({"R3/R4/R5/R6/R7/R10 strobes ", nm}, {25'd0, cs, wr, rd, ln, dr}, {25'd0, ev});
        // R1 R2 R9 handshake
        check({"R2/R9 ready ", nm}, {31'd0, rdy}, {31'd0, m_ready});
        if (!cs && !ev[6]) check({"R8 address ", nm}, {{(32-AW){1'b0}}, ad}, {{(32-AW){1'b0}}, m_addr});
        for (int l = 0; l < 2; l++)
            if (dr[l]) check({"R8 data ", nm}, {24'd0, dd[l*8 +: 8]}, {24'd0, m_data[l*8 +: 8]});
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check_inst("oe_low", 1'b1, PW_LO, rdy_a, cs_a, wr_a, rd_a, ln_a, dr_a, ad_a, do_a);
            check_inst("oe_high", 1'b0, PW_HI, rdy_b, cs_b, wr_b, rd_b, ln_b, dr_b, ad_b, do_b);
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
        req = 1'b1; haddr = a; hdata = d; hmask = m;
        while (!rdy_a) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic readback(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a;
        #1;
        check({tag, " readback oe_low"}, {16'd0, rb_a}, {16'd0, exp});
        check({tag, " readback oe_high"}, {16'd0, rb_b}, {16'd0, exp});
    endtask

    task automatic finish_run;
        done = 1;
        checks = checks + ck_a + ck_b;
        errors = errors + er_a + er_b;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset strobes", {27'd0, cs_a, wr_a, rd_a, ln_a}, {27'd0, 5'b11111});
        check("R1 reset drive/ready", {29'd0, dr_a, rdy_a}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, rdy_a}, 32'd1);
        issue(8'h10, 16'hA1B2, 2'b11);            // R7 both lanes
        req = 1'b0;
        issue(8'h10, 16'hFFFF, 2'b10);            // R7 upper only
        req = 1'b0;
        issue(8'h10, 16'h0000, 2'b01);            // R7 lower only
        req = 1'b0;
        issue(8'h10, 16'h1234, 2'b00);            // R9 empty request
        req = 1'b0;
        while (!rdy_a) @(negedge clk);
        readback(8'h10, 16'hFF00, "R7/R9");
        // R2 request held high through busy cycles: taken only when ready
        @(negedge clk);
        issue(8'h20, 16'h1357, 2'b11);
        issue(8'h21, 16'h2468, 2'b11);
        issue(8'h30, 16'hABCD, 2'b10);
        req = 1'b0;
        while (!rdy_a) @(negedge clk);
        repeat (2) @(negedge clk);
        readback(8'h20, 16'h1357, "R2");
        readback(8'h21, 16'h2468, "R2");
        readback(8'h30, 16'hAB00, "R7");
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule